// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block produces a 2:1 interlaced composite sync waveform for a television raster. It runs from a master clock at 32 times the line rate. A free-running slot counter splits each line into 32 clocks, and a half-line counter walks through the two fields of a frame. The half-line counter's position chooses the pulse pattern that the slot counter shapes. The result is a line sync 2 clocks wide, equalizing pulses 1 clock wide at twice the line rate, and serrated vertical sync pulses. Every edge falls on the master clock, so the line phase never slips through the vertical interval.

A level input selects a 525-line frame or a 625-line frame. Beside the mixed sync, the block drives a one-clock frame marker at the start of the odd field and a flag that is high for the whole vertical interval. Two active-low load inputs place the vertical position at the first equalizing pulse or at the first vertical sync pulse of a field, for slaving the raster to an outside timing source. Neither load input moves the line phase. Both line counts must be odd, so that the second field starts half a line in.

Top module: `csync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the slot and half-line counters clear and the outputs go idle after that edge (`msync_n`=1, `frame_sync`=0, `vint`=0). All outputs are registered, so each output shows the counter position of one clock earlier. The first edge after `rst` falls therefore shows the first equalizing pulse of the odd field (`msync_n`=0, `frame_sync`=1, `vint`=1).
- R2: Outside the vertical interval, `msync_n` is low for slots 0 and 1 of each 32-slot line and high for the other 30 slots.
- R3: Each field's vertical interval covers 18 half-lines (288 clocks), and `vint` is high for exactly those half-lines. The first 6 half-lines are equalizing: `msync_n` is low for the first clock of each 16-clock half-line. The next 6 are vertical sync: low for 14 clocks, then high for 2. The last 6 are equalizing again.
- R4: With `sel_625` low, a frame is 1050 half-lines, so `frame_sync` repeats every 16800 clocks. The even field's vertical interval begins at half-line 525, at slot 16 of its line.
- R5: With `sel_625` high, a frame is 1250 half-lines, so `frame_sync` repeats every 20000 clocks. The even field begins at half-line 625.
- R6: `frame_sync` is high for one clock per frame, only together with the first equalizing pulse of the odd field, and always with `msync_n` low and `vint` high.
- R7: While `rst_eq_n` is low, the half-line counter loads the first equalizing half-line of a field. If the next slot lies in slots 0–15 it loads half-line 0 (odd field); otherwise it loads the first half-line of the even field (525 or 625).
- R8: While `rst_vs_n` is low, the half-line counter loads the first vertical sync half-line: 6 when the next slot is in slots 0–15, otherwise the even-field start plus 6. When both load inputs are low, `rst_eq_n` wins.
- R9: The slot counter is never disturbed by a load or by a raster change. Line sync and equalizing edges stay on the same 32-clock grid across any such event.
- R10: If the half-line count is at or past the last half-line of the selected frame when a half-line ends, it wraps to the start of the odd field and keeps the line half. It goes to half-line 0 when the next half-line begins a line, and to half-line 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 times the line rate |
| rst | input | 1 | Synchronous active-high reset to the odd-field start |
| sel_625 | input | 1 | Raster select: 1 gives 625 lines, 0 gives 525 lines |
| rst_eq_n | input | 1 | Active-low load of the first equalizing half-line |
| rst_vs_n | input | 1 | Active-low load of the first vertical sync half-line |
| msync_n | output | 1 | Composite sync, active low |
| frame_sync | output | 1 | One-clock marker at the odd field's first equalizing pulse |
| vint | output | 1 | High for the whole vertical interval of each field |

## Verification
A slot counter that is off by one moves every line sync pulse off slots 0–1 within one line, which is 32 clocks. A half-line counter that wraps at the wrong count shows up as a wrong `frame_sync` period, but only at the frame boundary: 16800 or 20000 clocks later. A half-line count of the wrong parity swaps line sync and mid-line slots. It also puts the even-field interval on the wrong half of the line, which is visible within 16 clocks of the next vertical interval. A load that reaches the wrong half-line changes the equalizing or vertical sync pattern in the clock right after the output register.

// File: rtl/csg_pkg.sv
package csg_pkg;

  // Registered output bundle of the waveform shaper.
  typedef struct packed {
    logic msync_n;
    logic frame_sync;
    logic vint;
  } csg_out_t;

  localparam csg_out_t CSG_IDLE = '{msync_n: 1'b1, frame_sync: 1'b0, vint: 1'b0};

endpackage

// File: rtl/csg_line_timer.sv
// Free-running position inside one line, in master-clock slots.
module csg_line_timer #(
  parameter int SLOTS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic                     half_end,
  output logic                     nxt_second
);
  localparam int LW   = $clog2(SLOTS);
  localparam int HALF = SLOTS / 2;

  logic [LW-1:0] slot_nx;

  always_comb begin
    slot_nx    = (slot == LW'(SLOTS - 1)) ? '0 : slot + 1'b1;
    half_end   = (slot == LW'(HALF - 1)) || (slot == LW'(SLOTS - 1));
    nxt_second = (slot_nx >= LW'(HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= slot_nx;
  end
endmodule

// File: rtl/csg_halfline_counter.sv
// Vertical position in half-lines across one frame, with the two load inputs.
module csg_halfline_counter #(
  parameter int HW      = 11,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int PULSES  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_b,
  input  logic          half_end,
  input  logic          nxt_second,
  input  logic          ld_eq_n,
  input  logic          ld_vs_n,
  output logic [HW-1:0] hl
);
  logic [HW-1:0] fld, last, tgt_eq, tgt_vs;

  always_comb begin
    // a field holds as many half-lines as the frame holds lines
    fld    = sel_b ? HW'(LINES_B) : HW'(LINES_A);
    last   = (fld << 1) - 1'b1;
    // odd field starts on a line, even field half a line in
    tgt_eq = nxt_second ? fld : '0;
    tgt_vs = tgt_eq + HW'(PULSES);
  end

  always_ff @(posedge clk) begin
    if (rst)           hl <= '0;
    else if (!ld_eq_n) hl <= tgt_eq;
    else if (!ld_vs_n) hl <= tgt_vs;
    else if (half_end) begin
      if (hl >= last) hl <= HW'(nxt_second);   // parity-preserving wrap
      else            hl <= hl + 1'b1;
    end
  end
endmodule

// File: rtl/csg_sync_shaper.sv
// Decodes slot and half-line position into the registered output waveform.
module csg_sync_shaper
  import csg_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int HW      = 11,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int PULSES  = 6,
  parameter int HS_W    = 2,
  parameter int EQ_W    = 1,
  parameter int VS_LOW  = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel_b,
  input  logic [$clog2(SLOTS)-1:0] slot,
  input  logic [HW-1:0]            hl,
  output csg_out_t                 q
);
  localparam int LW   = $clog2(SLOTS);
  localparam int HALF = SLOTS / 2;

  logic [HW-1:0] fld, rel;
  logic [LW-1:0] hslot;
  logic          in_eq, in_vs, in_vi, low, fs;

  always_comb begin
    fld   = sel_b ? HW'(LINES_B) : HW'(LINES_A);
    rel   = (hl >= fld) ? hl - fld : hl;            // position inside the field
    hslot = (slot >= LW'(HALF)) ? slot - LW'(HALF) : slot;
    in_vs = (rel >= HW'(PULSES)) && (rel < HW'(2 * PULSES));
    in_vi = (rel < HW'(3 * PULSES));
    in_eq = in_vi && !in_vs;
    if (in_eq)      low = (hslot < LW'(EQ_W));
    else if (in_vs) low = (hslot < LW'(VS_LOW));
    else            low = (slot < LW'(HS_W));
    fs = (hl == '0) && (slot == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= CSG_IDLE;
    else     q <= '{msync_n: ~low, frame_sync: fs, vint: in_vi};
  end
endmodule

// File: rtl/csync_gen.sv
module csync_gen
  import csg_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int PULSES  = 6,
  parameter int HS_W    = 2,
  parameter int EQ_W    = 1,
  parameter int VS_LOW  = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_625,
  input  logic rst_eq_n,
  input  logic rst_vs_n,
  output logic msync_n,
  output logic frame_sync,
  output logic vint
);
  localparam int LW   = $clog2(SLOTS);
  localparam int MAXL = (LINES_A > LINES_B) ? LINES_A : LINES_B;
  localparam int HW   = $clog2(2 * MAXL);

  logic [LW-1:0] slot;
  logic [HW-1:0] hl;
  logic          half_end, nxt_second;
  csg_out_t      q;

  csg_line_timer #(.SLOTS(SLOTS)) u_line (
    .clk(clk), .rst(rst), .slot(slot), .half_end(half_end), .nxt_second(nxt_second)
  );

  csg_halfline_counter #(
    .HW(HW), .LINES_A(LINES_A), .LINES_B(LINES_B), .PULSES(PULSES)
  ) u_vert (
    .clk(clk), .rst(rst), .sel_b(sel_625), .half_end(half_end),
    .nxt_second(nxt_second), .ld_eq_n(rst_eq_n), .ld_vs_n(rst_vs_n), .hl(hl)
  );

  csg_sync_shaper #(
    .SLOTS(SLOTS), .HW(HW), .LINES_A(LINES_A), .LINES_B(LINES_B),
    .PULSES(PULSES), .HS_W(HS_W), .EQ_W(EQ_W), .VS_LOW(VS_LOW)
  ) u_shape (
    .clk(clk), .rst(rst), .sel_b(sel_625), .slot(slot), .hl(hl), .q(q)
  );

  assign msync_n    = q.msync_n;
  assign frame_sync = q.frame_sync;
  assign vint       = q.vint;
endmodule

// File: rtl/csync_gen_chk.sv
module csync_gen_chk #(
  parameter int SLOTS  = 32,
  parameter int PULSES = 6,
  parameter int VS_LOW = 14
) (
  input logic clk,
  input logic rst,
  input logic sel_625,
  input logic rst_eq_n,
  input logic rst_vs_n,
  input logic msync_n,
  input logic frame_sync,
  input logic vint
);
  localparam int VI_CLKS = 3 * PULSES * (SLOTS / 2);

  logic [15:0] low_run, vi_run;
  logic [2:0]  hist;
  logic        sel_d, rst_d, disturb, quiet;

  always_comb begin
    disturb = !rst_eq_n || !rst_vs_n || (sel_625 != sel_d);
    quiet   = (hist == 3'b000) && !disturb;
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    sel_d <= sel_625;
    if (rst) begin
      low_run <= '0;
      vi_run  <= '0;
      hist    <= '0;
    end else begin
      hist    <= {hist[1:0], disturb};
      low_run <= msync_n ? '0 : ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1);
      if (disturb)   vi_run <= '0;
      else if (vint) vi_run <= (vi_run == 16'hFFFF) ? vi_run : vi_run + 1'b1;
      else           vi_run <= '0;
    end
  end

  always @(negedge clk) begin
    if (rst_d === 1'b1)
      AST_RESET_IDLE: assert (msync_n && !frame_sync && !vint); // R1
  end

  AST_LINE_SYNC_WIDTH: assert property (@(posedge clk) disable iff (rst || !quiet)
    (!vint && $fell(msync_n)) |=> (!msync_n ##1 msync_n)); // R2
  AST_VS_LOW_MAX: assert property (@(posedge clk) disable iff (rst)
    low_run <= 16'(VS_LOW)); // R3
  AST_VI_SPAN_MAX: assert property (@(posedge clk) disable iff (rst)
    vi_run <= 16'(VI_CLKS)); // R3
  AST_FS_IN_VI: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> (vint && !msync_n)); // R6
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> !frame_sync); // R6
endmodule

bind csync_gen csync_gen_chk #(.SLOTS(SLOTS), .PULSES(PULSES), .VS_LOW(VS_LOW)) u_chk (
  .clk(clk), .rst(rst), .sel_625(sel_625), .rst_eq_n(rst_eq_n), .rst_vs_n(rst_vs_n),
  .msync_n(msync_n), .frame_sync(frame_sync), .vint(vint)
);

// File: tb/csync_gen_bench.sv
module csync_gen_bench;
  logic clk = 1'b0, rst = 1'b1, sel_625 = 1'b0, rst_eq_n = 1'b1, rst_vs_n = 1'b1;
  logic msync_n, frame_sync, vint;

  int checks = 0, fails = 0;
  int ml = 0, mh = 0;                 // expected slot and half-line
  int mis_ms = 0, mis_fs = 0, mis_vi = 0;
  bit done = 0;
  logic prev_ms = 1'b1, prev_vi = 1'b0;

  always #4 clk = ~clk;

  csync_gen u_csync_gen (
    .clk(clk), .rst(rst), .sel_625(sel_625), .rst_eq_n(rst_eq_n), .rst_vs_n(rst_vs_n),
    .msync_n(msync_n), .frame_sync(frame_sync), .vint(vint)
  );

  function automatic int fld_of(bit s);
    return s ? 625 : 525;
  endfunction

  function automatic int rel_of(int h, bit s);
    return (h >= fld_of(s)) ? h - fld_of(s) : h;
  endfunction

  // R2/R3 pattern from the requirement text
  function automatic bit x_ms(int l, int h, bit s);
    int r = rel_of(h, s);
    int c = l % 16;
    if (r < 6 || (r >= 12 && r < 18)) return !(c < 1);
    if (r < 12) return !(c < 14);
    return !(l < 2);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: predict outputs, advance expected position, sample at negedge
  task automatic cyc();
    bit ems, efs, evi;
    int f = fld_of(sel_625);
    int nl;
    prev_ms = msync_n;
    prev_vi = vint;
    if (rst) begin
      ems = 1; efs = 0; evi = 0; ml = 0; mh = 0;
    end else begin
      ems = x_ms(ml, mh, sel_625);
      efs = (ml == 0 && mh == 0);
      evi = (rel_of(mh, sel_625) < 18);
      nl = (ml + 1) % 32;
      if (!rst_eq_n)      mh = (nl >= 16) ? f : 0;
      else if (!rst_vs_n) mh = ((nl >= 16) ? f : 0) + 6;
      else if (ml == 15 || ml == 31) mh = (mh >= 2 * f - 1) ? ((nl >= 16) ? 1 : 0) : mh + 1;
      ml = nl;
    end
    @(posedge clk);
    @(negedge clk);
    if (msync_n !== ems)    mis_ms++;
    if (frame_sync !== efs) mis_fs++;
    if (vint !== evi)       mis_vi++;
  endtask

  task automatic clear_mis();
    mis_ms = 0; mis_fs = 0; mis_vi = 0;
  endtask

  task automatic report_mis(string req);
    chk(mis_ms == 0, req, "msync_n mismatching cycles", mis_ms, 0);
    chk(mis_fs == 0, req, "frame_sync mismatching cycles", mis_fs, 0);
    chk(mis_vi == 0, req, "vint mismatching cycles", mis_vi, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    clear_mis();
    sel_625 = 1'b0;
    do_reset();
    chk(msync_n === 1'b1 && frame_sync === 1'b0 && vint === 1'b0, "R1", "idle outputs in reset",
        {msync_n, frame_sync, vint}, 3'b100);
    cyc();
    chk(msync_n === 1'b0 && frame_sync === 1'b1 && vint === 1'b1, "R1", "first clock after reset",
        {msync_n, frame_sync, vint}, 3'b011);
  endtask

  // full frame in one raster mode: R2 R3 R4/R5 R6
  task automatic t_frame(bit s, string req);
    int f = fld_of(s);
    int fs_first = -1, fs_second = -1, fs_count = 0;
    int vi_clks = 0, vi_falls = 0, hs_lows = 0, even_rise = -1;
    clear_mis();
    sel_625 = s;
    do_reset();
    for (int i = 1; i <= 32 * f + 1; i++) begin
      cyc();
      if (frame_sync === 1'b1) begin
        fs_count++;
        if (fs_first < 0) fs_first = i; else if (fs_second < 0) fs_second = i;
      end
      if (i <= 16 * f) begin
        if (vint === 1'b1) vi_clks++;
        if (vint === 1'b1 && prev_ms === 1'b1 && msync_n === 1'b0) vi_falls++;
        if (vint === 1'b0 && msync_n === 1'b0) hs_lows++;
      end
      if (i > 2 && even_rise < 0 && vint === 1'b1 && prev_vi === 1'b0) even_rise = i;
    end
    chk(fs_second - fs_first == 32 * f, req, "frame_sync period", fs_second - fs_first, 32 * f);
    chk(fs_count == 2, "R6", "frame_sync pulses over one frame plus one", fs_count, 2);
    chk(even_rise == 16 * f + 1, req, "even field interval start (mid-line)", even_rise, 16 * f + 1);
    chk(vi_clks == 288, "R3", "vint clocks in odd field", vi_clks, 288);
    chk(vi_falls == 18, "R3", "sync falls inside odd-field interval", vi_falls, 18);
    chk(hs_lows == (((f - 1) - 18) / 2 + 1) * 2, "R2", "line sync low clocks in odd field",
        hs_lows, (((f - 1) - 18) / 2 + 1) * 2);
    report_mis(req);
  endtask

  task automatic t_eq_load();
    clear_mis();
    sel_625 = 1'b0;
    do_reset();
    repeat (100) cyc();                 // next slot is 5: odd-field target
    rst_eq_n = 1'b0;
    repeat (3) cyc();
    rst_eq_n = 1'b1;
    cyc();
    chk(vint === 1'b1, "R7", "vint after load in first half", vint, 1);
    repeat (40) cyc();
    while (ml != 19) cyc();             // next slot 20: even-field target
    rst_eq_n = 1'b0;
    cyc();
    rst_eq_n = 1'b1;
    cyc();
    chk(vint === 1'b1 && msync_n === 1'b1, "R7", "even-field load, slot 20 high",
        {vint, msync_n}, 2'b11);
    repeat (600) cyc();
    report_mis("R9");
  endtask

  task automatic t_vs_load();
    clear_mis();
    sel_625 = 1'b1;
    do_reset();
    repeat (400) cyc();
    while (ml != 4) cyc();
    rst_vs_n = 1'b0;
    cyc();
    rst_vs_n = 1'b1;
    cyc();
    chk(msync_n === 1'b0 && vint === 1'b1, "R8", "vertical sync low after load",
        {msync_n, vint}, 2'b01);
    repeat (300) cyc();
    while (ml != 4) cyc();
    rst_vs_n = 1'b0;
    rst_eq_n = 1'b0;
    cyc();
    rst_vs_n = 1'b1;
    rst_eq_n = 1'b1;
    cyc();
    chk(msync_n === 1'b1 && vint === 1'b1, "R8", "equalizing load wins over sync load",
        {msync_n, vint}, 2'b11);
    repeat (600) cyc();
    report_mis("R8");
  endtask

  task automatic t_raster_switch();
    int wait_fs = -1;
    clear_mis();
    sel_625 = 1'b1;
    do_reset();
    while (!(mh == 1101 && ml == 16)) cyc();
    sel_625 = 1'b0;                     // count now past the 525 frame end
    for (int i = 1; i <= 40; i++) begin
      cyc();
      if (wait_fs < 0 && frame_sync === 1'b1) wait_fs = i;
    end
    chk(wait_fs == 17, "R10", "frame_sync after wrap", wait_fs, 17);
    repeat (2000) cyc();
    report_mis("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_frame(1'b0, "R4");
    t_frame(1'b1, "R5");
    t_eq_load();
    t_vs_load();
    t_raster_switch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule